// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. The multiplier operand is recoded into radix-4 digits. Each digit is described by three control bits:

- **sign**: the negated multiplicand is used.
- **double**: the magnitude is twice the multiplicand.
- **single**: the magnitude is equal to the multiplicand.

Each digit picks one partial product from 0, ±M and ±2M. A negative partial product is formed by inverting the selected magnitude and adding a one at that partial product's least significant column. The partial products are sign-extended, aligned at a step of two columns and summed.

The multiply is captured in a single registered stage. A pulse on `in_valid` loads the product register at that clock edge, and `out_valid` reports the accepted operation one cycle later. When `in_valid` is low the register keeps its value. This lets the block sit in a datapath that issues one multiply per cycle or only occasionally.

Top module: `booth_mul_r4`

## Requirements
- R1: After a clock edge where `in_valid` is 1, `product` equals the signed product of `mcand` and `mplier` sampled at that edge, taken over the full 2*WIDTH bits without overflow.
- R2: `out_valid` is 1 in exactly the cycle after each edge where `in_valid` was 1, and 0 otherwise.
- R3: While `in_valid` is 0, `product` holds its previous value regardless of changes on `mcand` and `mplier`.
- R4: A clock edge with `rst_n` low clears `product` to 0 and `out_valid` to 0.
- R5: Digit k is decoded from the window formed by multiplier bits (2k+1, 2k, 2k-1), where bit -1 is a zero appended below the multiplier.
  - single = bit 2k XOR bit 2k-1.
  - double = 1 only for windows 011 and 100.
  - sign = bit 2k+1.
  - Windows 011 and 100 therefore select +2M and -2M, and multipliers such as 2 and 6 return 2*M and 6*M.
- R6: Windows 000 and 111 contribute zero even though 111 has its sign bit set. An all-ones multiplier (value -1) gives a product of exactly -M, and a zero operand gives 0.
- R7: Both operands at the most negative value give +2^(2*WIDTH-2). A most-negative multiplicand times -1 gives +2^(WIDTH-1) without wrapping.
- R8: For an odd `WIDTH`, the multiplier is sign-extended by one bit, so that (WIDTH+1)/2 digits are formed and signed products stay exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid; loads the product register |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| out_valid | output | 1 | Product valid, one cycle after an accepted input |
| product | output | 2*WIDTH | Registered signed product |

## Verification
The all-ones multiplier is the sharpest corner. A decoder that lets the sign bit of a 111 window inject its +1 correction would return a value off by powers of four from -M. A decoder that treats 111 as -1x would return a wildly wrong product.

Both operands at the most negative value check sign extension of the 2M magnitude. A magnitude only WIDTH bits wide would lose the top bit and flip the product's sign.

Multipliers of 2 and 6 exercise the ±2x windows, which a swapped double/single decode gets wrong. An odd-width instance catches a missing multiplier sign extension, which shows up as wrong results for every negative multiplier. Hold cycles with changing operands expose a register that loads without `in_valid`.

// File: rtl/booth_pkg.sv
// Shared types for the radix-4 Booth multiplier.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package booth_pkg;

    // One recoded radix-4 digit: sign, doubled magnitude, single magnitude.
    typedef struct packed {
        logic dir;   // 1: negated multiplicand
        logic shft;  // 1: magnitude is 2M
        logic add;   // 1: magnitude is 1M
    } booth_digit_t;

endpackage

// File: rtl/booth_digit_enc.sv
// Radix-4 digit encoder: turns one 3-bit overlapping multiplier window
// into the sign / double / single control triple.
// Assumes: win = {bit 2k+1, bit 2k, bit 2k-1}, bit -1 being a zero.
module booth_digit_enc
    import booth_pkg::*;
(
    input  logic [2:0]   win,
    output booth_digit_t dig
);

    // Decode the window into the three control bits.
    always_comb begin
        dig.add  = win[1] ^ win[0];
        dig.shft = (win[2] ^ win[1]) & ~(win[1] ^ win[0]);
        dig.dir  = win[2];
    end

    // A digit never selects both magnitudes (R5).
    always_comb begin
        p_mag_excl_r5: assert (!(dig.shft && dig.add))
            else $error("double and single magnitudes both selected");
    end

endmodule

// File: rtl/booth_pp_sel.sv
// Partial-product selector for digit K: picks 0, M or 2M, inverts it when
// the digit is negative, sign-extends to PW bits and aligns it at column 2K.
// The +1 that completes the negation is reported on neg for the adder.
// Assumes: WIDTH >= 2, PW = 2*WIDTH, 2*K < PW.
module booth_pp_sel
    import booth_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int PW    = 2 * WIDTH,
    parameter int K     = 0
) (
    input  logic [WIDTH-1:0] mcand,
    input  booth_digit_t     dig,
    output logic [PW-1:0]    pp,
    output logic             neg
);

    localparam int MW = WIDTH + 1;   // magnitude width, room for 2M
    localparam int XW = PW - MW;     // sign-extension bits

    logic [MW-1:0] mag;
    logic [MW-1:0] body;
    logic          live;
    logic [PW-1:0] ext;

    // Select the magnitude of this digit.
    always_comb begin
        if (dig.shft)
            mag = {mcand, 1'b0};
        else if (dig.add)
            mag = {mcand[WIDTH-1], mcand};
        else
            mag = '0;
    end

    // Apply the sign only to a non-zero digit so -0x stays zero.
    always_comb begin
        live = dig.shft | dig.add;
        neg  = dig.dir & live;
        body = neg ? ~mag : mag;
        ext  = {{XW{body[MW-1]}}, body};
        pp   = ext << (2 * K);
    end

    // A negation correction only comes from a negative digit (R6).
    always_comb begin
        p_neg_dir_r6: assert (!neg || dig.dir)
            else $error("correction bit without sign");
        // A digit with no magnitude contributes nothing (R6).
        p_zero_digit_r6: assert (dig.shft || dig.add || (pp == '0 && !neg))
            else $error("zero digit left a contribution");
    end

endmodule

// File: rtl/booth_pp_sum.sv
// Sums ND aligned partial products and the packed negation corrections.
// Assumes: all inputs already PW bits wide; result is taken modulo 2^PW.
module booth_pp_sum #(
    parameter int PW = 32,
    parameter int ND = 8
) (
    input  logic [ND-1:0][PW-1:0] pps,
    input  logic [PW-1:0]         fix,
    output logic [PW-1:0]         sum
);

    // Accumulate the correction word and every partial product.
    always_comb begin
        sum = fix;
        for (int k = 0; k < ND; k++) begin
            sum = sum + pps[k];
        end
    end

endmodule

// File: rtl/booth_mul_r4.sv
// Radix-4 Booth signed multiplier with one registered output stage.
// Recodes the multiplier into (WIDTH+1)/2 digits, selects partial
// products, sums them and loads the product register on in_valid.
// Assumes: WIDTH >= 2; synchronous active-low reset.
module booth_mul_r4
    import booth_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] product
);

    localparam int ND = (WIDTH + 1) / 2;   // digit count
    localparam int YW = 2 * ND;            // even multiplier width
    localparam int PW = 2 * WIDTH;         // product width

    logic [YW:0]            yx;
    logic [ND-1:0][PW-1:0]  pps;
    logic [ND-1:0]          negs;
    logic [PW-1:0]          fix;
    logic [PW-1:0]          sum;

    // Widen the multiplier to an even width and append the zero bit.
    generate
        if (YW == WIDTH) begin : g_even
            assign yx = {mplier, 1'b0};
        end else begin : g_odd
            assign yx = {mplier[WIDTH-1], mplier, 1'b0};
        end
    endgenerate

    // One encoder and one selector per digit.
    generate
        for (genvar k = 0; k < ND; k++) begin : g_digit
            booth_digit_t dig;

            booth_digit_enc u_enc (
                .win (yx[2*k+2 : 2*k]),
                .dig (dig)
            );

            booth_pp_sel #(
                .WIDTH (WIDTH),
                .PW    (PW),
                .K     (k)
            ) u_sel (
                .mcand (mcand),
                .dig   (dig),
                .pp    (pps[k]),
                .neg   (negs[k])
            );
        end
    endgenerate

    // Place each negation +1 at its digit's lowest column.
    always_comb begin
        fix = '0;
        for (int k = 0; k < ND; k++) begin
            fix[2*k] = negs[k];
        end
    end

    booth_pp_sum #(
        .PW (PW),
        .ND (ND)
    ) u_sum (
        .pps (pps),
        .fix (fix),
        .sum (sum)
    );

    // Output stage: load on in_valid, flag validity one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                product <= sum;
        end
    end

    // ---------------- assertions ----------------
    logic                 prev_live;
    logic signed [PW-1:0] ref_prod;

    // Track that the previous edge was out of reset.
    always_ff @(posedge clk) begin
        prev_live <= rst_n;
    end

    // Independent wide signed product for checking.
    always_comb begin
        ref_prod = $signed({{WIDTH{mcand[WIDTH-1]}}, mcand}) *
                   $signed({{WIDTH{mplier[WIDTH-1]}}, mplier});
    end

    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && $past(in_valid)) |-> (product == $past(ref_prod)))
        else $error("product mismatch");

    p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prev_live |-> (out_valid == $past(in_valid)))
        else $error("out_valid not one cycle after in_valid");

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_live && !$past(in_valid)) |-> $stable(product))
        else $error("product changed without in_valid");

endmodule

// File: tb/booth_mul_r4_test.sv
module booth_mul_r4_test;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int WO = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  mcand = '0, mplier = '0;
    logic          out_valid;
    logic [2*W-1:0] product;

    logic           in_valid_o = 1'b0;
    logic [WO-1:0]  mcand_o = '0, mplier_o = '0;
    logic           out_valid_o;
    logic [2*WO-1:0] product_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth_mul_r4 #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .mcand(mcand), .mplier(mplier),
        .out_valid(out_valid), .product(product)
    );

    booth_mul_r4 #(.WIDTH(WO)) uut_odd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid_o),
        .mcand(mcand_o), .mplier(mplier_o),
        .out_valid(out_valid_o), .product(product_o)
    );

    // {multiplicand, multiplier, requirement tag}
    localparam logic [31:0] VEC [14] = '{
        {16'h1234, 16'h0000},   // R6 zero multiplier
        {16'h0000, 16'hBEEF},   // R6 zero multiplicand
        {16'h8000, 16'h8000},   // R7 most negative squared
        {16'h8000, 16'hFFFF},   // R7 most negative times -1
        {16'h1234, 16'hFFFF},   // R6 all-ones multiplier
        {16'h7FFF, 16'hFFFF},   // R6 all-ones multiplier
        {16'hFFFF, 16'hFFFF},   // R6 -1 times -1
        {16'h0123, 16'h0002},   // R5 window 100
        {16'h0123, 16'h0006},   // R5 window 011
        {16'h7FFF, 16'h7FFF},   // R1 largest positive
        {16'h8000, 16'h7FFF},   // R1 mixed extremes
        {16'h5555, 16'hAAAA},   // R5 alternating windows
        {16'hA5A5, 16'h0003},   // R5 window 110 then 001
        {16'h0001, 16'h8000}    // R1 most negative multiplier
    };

    function automatic logic [2*W-1:0] ref16(logic [W-1:0] a, logic [W-1:0] b);
        return $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    endfunction

    function automatic logic [2*WO-1:0] ref7(logic [WO-1:0] a, logic [WO-1:0] b);
        return $signed({{WO{a[WO-1]}}, a}) * $signed({{WO{b[WO-1]}}, b});
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one wide multiply and check it one cycle later (R1, R2).
    task automatic run16(logic [W-1:0] a, logic [W-1:0] b, string tag);
        @(negedge clk);
        mcand = a; mplier = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R2 valid"}, 64'(out_valid), 64'd1);
        check(tag, 64'(product), 64'(ref16(a, b)));
    endtask

    // Apply one odd-width multiply and check it (R8).
    task automatic run7(logic [WO-1:0] a, logic [WO-1:0] b);
        @(negedge clk);
        mcand_o = a; mplier_o = b; in_valid_o = 1'b1;
        @(negedge clk);
        in_valid_o = 1'b0;
        check("R8 odd valid", 64'(out_valid_o), 64'd1);
        check("R8 odd product", 64'(product_o), 64'(ref7(a, b)));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [2*W-1:0] held;
        // R4: reset with live inputs clears the outputs.
        in_valid = 1'b1; mcand = 16'h1234; mplier = 16'h5678;
        repeat (3) @(negedge clk);
        check("R4 out_valid", 64'(out_valid), 64'd0);
        check("R4 product", 64'(product), 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk.
        for (int i = 0; i < 14; i++) begin
            run16(VEC[i][31:16], VEC[i][15:0], "R1 table");
        end

        // R2: no output strobe without an input strobe.
        @(negedge clk);
        check("R2 idle", 64'(out_valid), 64'd0);

        // R3: operands change while in_valid is low.
        held = product;
        mcand = 16'h7777; mplier = 16'h3333;
        @(negedge clk);
        mcand = 16'h8001; mplier = 16'hFFFE;
        @(negedge clk);
        check("R3 hold", 64'(product), 64'(held));
        check("R3 no valid", 64'(out_valid), 64'd0);

        // Back-to-back accepts (R1, R2).
        @(negedge clk);
        mcand = 16'h0F0F; mplier = 16'hF0F0; in_valid = 1'b1;
        @(negedge clk);
        check("R1 b2b first", 64'(product), 64'(ref16(16'h0F0F, 16'hF0F0)));
        mcand = 16'hC001; mplier = 16'h3FFD;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b valid", 64'(out_valid), 64'd1);
        check("R1 b2b second", 64'(product), 64'(ref16(16'hC001, 16'h3FFD)));

        // Random wide operands.
        for (int i = 0; i < 300; i++) begin
            run16(W'($urandom), W'($urandom), "R1 random");
        end

        // R8: odd width corners and random.
        run7(7'h40, 7'h40);
        run7(7'h40, 7'h7F);
        run7(7'h15, 7'h7F);
        run7(7'h3F, 7'h41);
        for (int i = 0; i < 200; i++) begin
            run7(WO'($urandom), WO'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule